// File: doc/BRIEF.md
# Request-Phase Parity Generator and Checker

This block protects the request phase of an active-low system bus with two parity lines. A request occupies two consecutive bus clock cycles. In the first cycle the address field carries the transaction address. In the second cycle the same field carries transaction-type information. A five-bit request code is present in both cycles. Each parity line covers one group of lines. The two groups are the upper twelve address lines (address bits 35:24), and the lower twenty-one address lines (bits 23:3) together with the request code. Which parity line covers which group swaps between the first and the second cycle.

The initiator half accepts a request as logical (true-polarity) fields. It drives the request onto the bus as line levels, asserting the strobe low in the first cycle and placing the matching parity levels beside the address and code. The receiver half watches the bus. It starts a check when it samples the strobe low. It recomputes the parity in that cycle and in the one that follows, and reports any disagreement one cycle later. Both halves use the same parity function, so a bus looped back from the initiator to the receiver never reports an error.

Top module: `rqpar_unit`

## Requirements
- R1: While reset is high and after it is released with no request, the bus outputs are idle. The strobe, every address line, every code line and both parity lines are high, and the error pulse, mask and subphase flag are 0.
- R2: A parity level is 1 when its covered lines hold an even number of low levels, and 0 when they hold an odd number. In the first cycle, parity line 0 covers address lines 32:21 of the 33-bit field. Parity line 1 covers address lines 20:0 together with the five code lines.
- R3: In the second cycle the coverage swaps. Parity line 1 covers address lines 32:21. Parity line 0 covers address lines 20:0 together with the code lines.
- R4: A start sampled while the initiator is idle produces, from the next cycle, one cycle with the strobe low carrying the inverted first-cycle address and code. That cycle is followed by one cycle with the strobe high carrying the inverted type field and second code, and then the idle bus.
- R5: A start sampled during the initiator's first cycle is ignored, and the second cycle keeps the original fields. A start sampled during the second cycle begins a new request in the cycle that follows.
- R6: If the receiver samples the strobe low outside a second cycle and the parity levels disagree with R2, then in the next cycle the error pulse is 1. The mask has a 1 for each disagreeing parity line (bit n for line n), and the subphase flag is 0.
- R7: In the cycle after such a first cycle, a disagreement with R3 raises the error pulse in the following cycle, with the mask set as in R6 and the subphase flag set to 1.
- R8: No check is made in a cycle that is neither a first nor a second cycle. A strobe sampled low during a second cycle is treated as part of that second cycle, not as a new request.
- R9: With the initiator outputs looped back into the receiver inputs, the error pulse stays 0 for any request.
- R10: The error pulse lasts one cycle per failing subphase. While the pulse is 0, the mask is 00 and the subphase flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ini_go | input | 1 | Start a request (ignored during the first cycle) |
| ini_addr | input | 33 | First-cycle address, true polarity, bits 35:3 |
| ini_code1 | input | 5 | First-cycle request code, true polarity |
| ini_type | input | 33 | Second-cycle type field, true polarity |
| ini_code2 | input | 5 | Second-cycle request code, true polarity |
| out_strobe_l | output | 1 | Driven strobe level, low in the first cycle |
| out_addr_l | output | 33 | Driven address line levels |
| out_code_l | output | 5 | Driven code line levels |
| out_par_l | output | 2 | Driven parity line levels |
| in_strobe_l | input | 1 | Observed strobe level |
| in_addr_l | input | 33 | Observed address line levels |
| in_code_l | input | 5 | Observed code line levels |
| in_par_l | input | 2 | Observed parity line levels |
| err_pulse | output | 1 | One-cycle parity mismatch indication |
| err_mask | output | 2 | Failing parity lines |
| err_sub2 | output | 1 | 1 when the failure was in the second cycle |

## Verification
The hardest case to reach from the ports is a corrupted second cycle. A looped-back bus can never produce one, so the bench takes over the receiver inputs. It drives a correct first cycle and then a second cycle with one parity level inverted, placing the error after the coverage swap. The bench also asserts the strobe in two adjacent cycles. This shows that the second strobe is checked with the swapped coverage and does not open a new request. A following cycle with bad parity and no strobe must stay silent.

// File: rtl/rqpar_pkg.sv
package rqpar_pkg;

    localparam int RQ_ADDR_W = 33;
    localparam int RQ_CODE_W = 5;
    localparam int RQ_LOW_W  = 21;
    localparam int RQ_HIGH_W = RQ_ADDR_W - RQ_LOW_W;

    typedef enum logic [1:0] {
        GS_IDLE = 2'd0,
        GS_SUB1 = 2'd1,
        GS_SUB2 = 2'd2
    } gen_state_t;

    typedef struct packed {
        logic [RQ_ADDR_W-1:0] addr;
        logic [RQ_CODE_W-1:0] code;
    } rq_word_t;

    typedef struct packed {
        rq_word_t first;
        rq_word_t second;
    } rq_req_t;

    // Level of a parity line: 1 when the group holds an even count of lows.
    function automatic logic grp_level_hi(input rq_word_t w);
        logic [RQ_HIGH_W-1:0] g;
        g = w.addr[RQ_ADDR_W-1:RQ_LOW_W];
        return ~(^(~g));
    endfunction

    function automatic logic grp_level_lo(input rq_word_t w);
        logic [RQ_LOW_W+RQ_CODE_W-1:0] g;
        g = {w.addr[RQ_LOW_W-1:0], w.code};
        return ~(^(~g));
    endfunction

    // Both parity levels for a word of line levels; sub2 swaps the lines.
    function automatic logic [1:0] rq_parity(input rq_word_t w, input logic sub2);
        logic hi;
        logic lo;
        hi = grp_level_hi(w);
        lo = grp_level_lo(w);
        return sub2 ? {hi, lo} : {lo, hi};
    endfunction

endpackage

// File: rtl/rqpar_gen.sv
module rqpar_gen
    import rqpar_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 go,
    input  rq_req_t              req,
    output logic                 strobe_l,
    output rq_word_t             word_l,
    output logic [1:0]           par_l
);

    gen_state_t state_q;
    rq_req_t    hold_q;
    logic       accept;

    assign accept = go && (state_q != GS_SUB1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GS_IDLE;
            hold_q  <= '0;
        end else begin
            if (accept) begin
                state_q <= GS_SUB1;
                hold_q  <= req;
            end else if (state_q == GS_SUB1) begin
                state_q <= GS_SUB2;
            end else begin
                state_q <= GS_IDLE;
            end
        end
    end

    always_comb begin
        strobe_l = 1'b1;
        word_l   = '1;
        case (state_q)
            GS_SUB1: begin
                strobe_l = 1'b0;
                word_l   = ~hold_q.first;
            end
            GS_SUB2: begin
                word_l   = ~hold_q.second;
            end
            default: begin
                word_l   = '1;
            end
        endcase
        par_l = rq_parity(word_l, state_q == GS_SUB2);
    end

endmodule

// File: rtl/rqpar_chk.sv
module rqpar_chk
    import rqpar_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       strobe_l,
    input  rq_word_t   word_l,
    input  logic [1:0] par_l,
    output logic       err_pulse,
    output logic [1:0] err_mask,
    output logic       err_sub2
);

    logic       in_sub2_q;
    logic       act_sub1;
    logic       active;
    logic [1:0] expect_par;
    logic [1:0] diff;

    assign act_sub1   = !strobe_l && !in_sub2_q;
    assign active     = act_sub1 || in_sub2_q;
    assign expect_par = rq_parity(word_l, in_sub2_q);
    assign diff       = (expect_par ^ par_l) & {2{active}};

    always_ff @(posedge clk) begin
        if (rst) begin
            in_sub2_q <= 1'b0;
            err_pulse <= 1'b0;
            err_mask  <= 2'b00;
            err_sub2  <= 1'b0;
        end else begin
            in_sub2_q <= act_sub1;
            err_pulse <= |diff;
            err_mask  <= diff;
            err_sub2  <= in_sub2_q && (|diff);
        end
    end

endmodule

// File: rtl/rqpar_unit.sv
module rqpar_unit
    import rqpar_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ini_go,
    input  logic [RQ_ADDR_W-1:0] ini_addr,
    input  logic [RQ_CODE_W-1:0] ini_code1,
    input  logic [RQ_ADDR_W-1:0] ini_type,
    input  logic [RQ_CODE_W-1:0] ini_code2,
    output logic                 out_strobe_l,
    output logic [RQ_ADDR_W-1:0] out_addr_l,
    output logic [RQ_CODE_W-1:0] out_code_l,
    output logic [1:0]           out_par_l,
    input  logic                 in_strobe_l,
    input  logic [RQ_ADDR_W-1:0] in_addr_l,
    input  logic [RQ_CODE_W-1:0] in_code_l,
    input  logic [1:0]           in_par_l,
    output logic                 err_pulse,
    output logic [1:0]           err_mask,
    output logic                 err_sub2
);

    rq_req_t  ini_req;
    rq_word_t gen_word;
    rq_word_t rx_word;

    assign ini_req.first.addr  = ini_addr;
    assign ini_req.first.code  = ini_code1;
    assign ini_req.second.addr = ini_type;
    assign ini_req.second.code = ini_code2;

    assign out_addr_l   = gen_word.addr;
    assign out_code_l   = gen_word.code;
    assign rx_word.addr = in_addr_l;
    assign rx_word.code = in_code_l;

    rqpar_gen u_gen (
        .clk      (clk),
        .rst      (rst),
        .go       (ini_go),
        .req      (ini_req),
        .strobe_l (out_strobe_l),
        .word_l   (gen_word),
        .par_l    (out_par_l)
    );

    rqpar_chk u_chk (
        .clk       (clk),
        .rst       (rst),
        .strobe_l  (in_strobe_l),
        .word_l    (rx_word),
        .par_l     (in_par_l),
        .err_pulse (err_pulse),
        .err_mask  (err_mask),
        .err_sub2  (err_sub2)
    );

endmodule

// File: rtl/rqpar_sva.sv
module rqpar_sva (
    input logic       clk,
    input logic       rst,
    input logic       ini_go,
    input logic       out_strobe_l,
    input logic       in_strobe_l,
    input logic       err_pulse,
    input logic [1:0] err_mask,
    input logic       err_sub2
);

    // R4: the driven strobe is low for exactly one cycle per request
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (rst)
        !out_strobe_l |=> out_strobe_l);

    // R5: a start during the second cycle yields a strobe right after it
    a_r5_back_to_back: assert property (@(posedge clk) disable iff (rst)
        ($past(!out_strobe_l) && ini_go) |=> !out_strobe_l);

    // R6: a first-cycle error never repeats as a first-cycle error next cycle
    a_r6_sub1_once: assert property (@(posedge clk) disable iff (rst)
        (err_pulse && !err_sub2) |=> !(err_pulse && !err_sub2));

    // R7: a second-cycle error follows a strobe two cycles earlier
    a_r7_sub2_origin: assert property (@(posedge clk) disable iff (rst)
        (err_pulse && err_sub2) |-> ($past(in_strobe_l, 2) == 1'b0));

    // R8: two quiet strobe cycles leave no error behind
    a_r8_quiet_bus: assert property (@(posedge clk) disable iff (rst)
        (in_strobe_l && $past(in_strobe_l)) |=> !err_pulse);

    // R10: a pulse always names at least one failing line
    a_r10_mask_set: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> (err_mask != 2'b00));

endmodule

bind rqpar_unit rqpar_sva u_sva (
    .clk          (clk),
    .rst          (rst),
    .ini_go       (ini_go),
    .out_strobe_l (out_strobe_l),
    .in_strobe_l  (in_strobe_l),
    .err_pulse    (err_pulse),
    .err_mask     (err_mask),
    .err_sub2     (err_sub2)
);

// File: tb/test_rqpar_unit.sv
module test_rqpar_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ini_go = 1'b0;
    logic [32:0] ini_addr = '0;
    logic [4:0]  ini_code1 = '0;
    logic [32:0] ini_type = '0;
    logic [4:0]  ini_code2 = '0;
    logic        out_strobe_l;
    logic [32:0] out_addr_l;
    logic [4:0]  out_code_l;
    logic [1:0]  out_par_l;
    logic        loop = 1'b0;
    logic        tb_strobe_l = 1'b1;
    logic [32:0] tb_addr_l = '1;
    logic [4:0]  tb_code_l = '1;
    logic [1:0]  tb_par_l = 2'b11;
    logic        in_strobe_l;
    logic [32:0] in_addr_l;
    logic [4:0]  in_code_l;
    logic [1:0]  in_par_l;
    logic        err_pulse;
    logic [1:0]  err_mask;
    logic        err_sub2;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    assign in_strobe_l = loop ? out_strobe_l : tb_strobe_l;
    assign in_addr_l   = loop ? out_addr_l   : tb_addr_l;
    assign in_code_l   = loop ? out_code_l   : tb_code_l;
    assign in_par_l    = loop ? out_par_l    : tb_par_l;

    rqpar_unit i_rqpar_unit (
        .clk(clk), .rst(rst), .ini_go(ini_go), .ini_addr(ini_addr),
        .ini_code1(ini_code1), .ini_type(ini_type), .ini_code2(ini_code2),
        .out_strobe_l(out_strobe_l), .out_addr_l(out_addr_l),
        .out_code_l(out_code_l), .out_par_l(out_par_l),
        .in_strobe_l(in_strobe_l), .in_addr_l(in_addr_l),
        .in_code_l(in_code_l), .in_par_l(in_par_l),
        .err_pulse(err_pulse), .err_mask(err_mask), .err_sub2(err_sub2)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // 1 when the low n bits of v hold an even number of zeros
    function automatic logic even_lows(input logic [63:0] v, input int n);
        int z = 0;
        for (int i = 0; i < n; i++) if (!v[i]) z++;
        return (z % 2) == 0;
    endfunction

    function automatic logic [1:0] ref_par(input logic [32:0] a, input logic [4:0] c,
                                           input logic second);
        logic hi;
        logic lo;
        hi = even_lows({52'd0, a[32:21]}, 12);
        lo = even_lows({38'd0, a[20:0], c}, 26);
        return second ? {hi, lo} : {lo, hi};
    endfunction

    task automatic err_idle(input string req);
        chk({req, " pulse"}, {63'd0, err_pulse}, 64'd0);
        chk({req, " mask"}, {62'd0, err_mask}, 64'd0);
        chk({req, " sub"}, {63'd0, err_sub2}, 64'd0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 strobe in reset", {63'd0, out_strobe_l}, 64'd1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 strobe", {63'd0, out_strobe_l}, 64'd1);
        chk("R1 addr", {31'd0, out_addr_l}, {31'd0, {33{1'b1}}});
        chk("R1 code", {59'd0, out_code_l}, 64'h1f);
        chk("R1 par", {62'd0, out_par_l}, 64'd3);
        err_idle("R1 err");
    endtask

    // R4 R2 R3 R9: full request on the looped-back bus
    task automatic t_gen(input logic [32:0] a, input logic [4:0] c1,
                         input logic [32:0] ty, input logic [4:0] c2);
        loop = 1'b1;
        ini_addr = a; ini_code1 = c1; ini_type = ty; ini_code2 = c2; ini_go = 1'b1;
        @(negedge clk);
        ini_go = 1'b0;
        chk("R4 sub1 strobe", {63'd0, out_strobe_l}, 64'd0);
        chk("R4 sub1 addr", {31'd0, out_addr_l}, {31'd0, ~a});
        chk("R4 sub1 code", {59'd0, out_code_l}, {59'd0, ~c1});
        chk("R2 sub1 par", {62'd0, out_par_l}, {62'd0, ref_par(~a, ~c1, 1'b0)});
        err_idle("R9 before");
        @(negedge clk);
        chk("R4 sub2 strobe", {63'd0, out_strobe_l}, 64'd1);
        chk("R4 sub2 addr", {31'd0, out_addr_l}, {31'd0, ~ty});
        chk("R4 sub2 code", {59'd0, out_code_l}, {59'd0, ~c2});
        chk("R3 sub2 par", {62'd0, out_par_l}, {62'd0, ref_par(~ty, ~c2, 1'b1)});
        err_idle("R9 sub1 loop");
        @(negedge clk);
        chk("R4 idle strobe", {63'd0, out_strobe_l}, 64'd1);
        chk("R4 idle addr", {31'd0, out_addr_l}, {31'd0, {33{1'b1}}});
        err_idle("R9 sub2 loop");
        @(negedge clk);
        err_idle("R9 after");
        loop = 1'b0;
    endtask

    // R5: start during first cycle ignored, start during second accepted
    task automatic t_restart;
        loop = 1'b1;
        ini_addr = 33'h0_1234_5678; ini_code1 = 5'h03;
        ini_type = 33'h1_0F0F_0F0F; ini_code2 = 5'h1c; ini_go = 1'b1;
        @(negedge clk);
        ini_addr = 33'h1_FFFF_0000; ini_code1 = 5'h11;
        ini_type = 33'h0_AAAA_5555; ini_code2 = 5'h0a;
        @(negedge clk);
        chk("R5 ignored start type", {31'd0, out_addr_l}, {31'd0, ~33'h1_0F0F_0F0F});
        chk("R5 ignored start code", {59'd0, out_code_l}, {59'd0, ~5'h1c});
        @(negedge clk);
        ini_go = 1'b0;
        chk("R5 restart strobe", {63'd0, out_strobe_l}, 64'd0);
        chk("R5 restart addr", {31'd0, out_addr_l}, {31'd0, ~33'h1_FFFF_0000});
        err_idle("R9 restart");
        @(negedge clk);
        chk("R5 restart type", {31'd0, out_addr_l}, {31'd0, ~33'h0_AAAA_5555});
        @(negedge clk);
        @(negedge clk);
        err_idle("R9 restart end");
        loop = 1'b0;
    endtask

    task automatic drive(input logic s, input logic [32:0] a, input logic [4:0] c,
                         input logic [1:0] p);
        tb_strobe_l = s; tb_addr_l = a; tb_code_l = c; tb_par_l = p;
    endtask

    // R6 R10: bad first-cycle parity
    task automatic t_rx_sub1(input logic [1:0] flip);
        logic [32:0] a = 33'h0_DEAD_BEEF;
        logic [4:0]  c = 5'h15;
        drive(1'b0, a, c, ref_par(a, c, 1'b0) ^ flip);
        @(negedge clk);
        drive(1'b1, ~a, c, ref_par(~a, c, 1'b1));
        chk("R6 pulse", {63'd0, err_pulse}, 64'd1);
        chk("R6 mask", {62'd0, err_mask}, {62'd0, flip});
        chk("R6 sub flag", {63'd0, err_sub2}, 64'd0);
        @(negedge clk);
        drive(1'b1, '1, '1, 2'b11);
        err_idle("R10 after sub1");
        @(negedge clk);
    endtask

    // R7 R10: good first cycle, bad second cycle
    task automatic t_rx_sub2(input logic [1:0] flip);
        logic [32:0] a = 33'h1_0000_0001;
        logic [4:0]  c = 5'h00;
        logic [32:0] t = 33'h0_7777_3333;
        drive(1'b0, a, c, ref_par(a, c, 1'b0));
        @(negedge clk);
        drive(1'b1, t, 5'h1f, ref_par(t, 5'h1f, 1'b1) ^ flip);
        err_idle("R7 clean sub1");
        @(negedge clk);
        drive(1'b1, '1, '1, 2'b11);
        chk("R7 pulse", {63'd0, err_pulse}, 64'd1);
        chk("R7 mask", {62'd0, err_mask}, {62'd0, flip});
        chk("R7 sub flag", {63'd0, err_sub2}, 64'd1);
        @(negedge clk);
        err_idle("R10 one cycle");
    endtask

    // R8: idle cycles unchecked; strobe in second cycle is not a new request
    task automatic t_rx_quiet;
        logic [32:0] a = 33'h0_0000_00FF;
        logic [4:0]  c = 5'h07;
        drive(1'b1, a, c, ~ref_par(a, c, 1'b0));
        @(negedge clk);
        @(negedge clk);
        err_idle("R8 idle bad parity");
        drive(1'b0, a, c, ref_par(a, c, 1'b0));
        @(negedge clk);
        // second strobe: checked with swapped coverage, line 0 corrupted
        drive(1'b0, a, c, ref_par(a, c, 1'b1) ^ 2'b01);
        @(negedge clk);
        drive(1'b1, a, c, 2'b00 ^ ~ref_par(a, c, 1'b0) ^ ~ref_par(a, c, 1'b1));
        chk("R8 strobe in sub2 pulse", {63'd0, err_pulse}, 64'd1);
        chk("R8 strobe in sub2 flag", {63'd0, err_sub2}, 64'd1);
        chk("R8 strobe in sub2 mask", {62'd0, err_mask}, 64'd1);
        @(negedge clk);
        drive(1'b1, '1, '1, 2'b11);
        err_idle("R8 no new request");
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_gen(33'h0, 5'h0, 33'h0, 5'h0);
        t_gen(33'h1_FFFF_FFFF, 5'h1f, 33'h1_FFFF_FFFF, 5'h1f);
        t_gen(33'h1_0000_0000, 5'h01, 33'h0_0010_0000, 5'h10);
        t_gen(33'h0_1357_9BDF, 5'h0b, 33'h1_2468_ACE0, 5'h16);
        t_restart();
        t_rx_sub1(2'b01);
        t_rx_sub1(2'b10);
        t_rx_sub1(2'b11);
        t_rx_sub2(2'b10);
        t_rx_sub2(2'b01);
        t_rx_quiet();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule